// File: doc/BRIEF.md
# Single-Channel Paced DMA Transfer Engine

This block is one DMA channel. It copies 8-bit items between a peripheral data register and a memory buffer without processor help. Each item is paced by a request from the peripheral. Software programs a peripheral address, a memory address, a 16-bit item count and a control word through a small register port, then sets the enable bit. For every request the engine does a read of one byte on a simple request/grant bus. It then writes that byte to the other side, pulses an acknowledge back to the peripheral, and counts the item off.

The engine is a six-state machine. In `S_OFF` it waits for the enable bit; when the bit is seen it latches a shadow copy of the two base addresses and the count and moves to `S_WAIT`. `S_WAIT` returns to `S_OFF` when enable is cleared, goes to `S_DONE` when the count is zero, and goes to `S_READ` on a peripheral request. `S_READ` holds a read until grant, then goes to `S_WRITE`, or to `S_OFF` on a bus error. `S_WRITE` holds a write until grant, then goes to `S_ACK`, or to `S_OFF` on a bus error. `S_ACK` pulses the acknowledge and updates the count and addresses. It then goes to `S_DONE` after the last item of a one-shot run, otherwise to `S_WAIT`. `S_DONE` ignores requests and goes to `S_OFF` when enable is cleared.

Three sticky flags record completion, the half-way point and a bus error. Each flag drives the interrupt output when its own enable bit is set. In circular mode the count and the addresses are restored from the shadow copy when the last item is done, and the channel keeps running.

Top module: `dma_chan`

## Requirements
- R1: Direction bit set: each item reads the memory address and writes the peripheral address. Direction bit clear: each item reads the peripheral address and writes the memory address.
- R2: With memory increment set, the memory address advances by one after each item; otherwise it stays at the programmed base. Peripheral increment does the same for the peripheral address.
- R3: The remaining count drops by one per completed item. In one-shot mode, reaching zero sets the complete flag, and no later request is serviced until the channel is disabled and re-armed.
- R4: In circular mode, finishing the last item sets the complete flag. It also reloads the count latched at enable and restarts both addresses at their bases, and the enable bit stays set.
- R5: A write to the count register is ignored while the enable bit is set or the engine is not yet back in `S_OFF`. While the channel is off, such a write is accepted.
- R6: The half flag sets when the remaining count after an item is at or below the latched count shifted right by one. It sets at most once per pass.
- R7: A bus error on a granted read or write sets the error flag and clears the enable bit. The item is not acknowledged and the count is unchanged.
- R8: Flags are sticky until a 1 is written to the matching bit of the flag-clear register. The interrupt output is the OR of the flags whose enable bits are set.
- R9: Each item is one granted read followed by one granted write. Address and direction are held until grant. The acknowledge is a single-cycle pulse in the cycle after the write grant.
- R10: After reset every register reads zero, the engine is in `S_OFF`, and the bus request, acknowledge and interrupt outputs are low.
- R11: Without a peripheral request, an enabled channel issues no bus request and the count does not change.
- R12: Register map, by word index on `reg_addr`: 0 control, 1 count, 2 peripheral address, 3 memory address, 4 flags (read), 5 flag clear (write). Control bits: 0 enable, 1 direction, 2 circular, 3 memory increment, 4 peripheral increment, 6:5 priority (stored, read back), 7 complete-interrupt enable, 8 half-interrupt enable, 9 error-interrupt enable. Flag bits: 0 complete, 1 half, 2 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| per_req | input | 1 | Peripheral request for one item |
| per_ack | output | 1 | One-cycle acknowledge after the item's write |
| bus_req | output | 1 | Bus access request, held until grant |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with grant |
| bus_gnt | input | 1 | Access accepted this cycle |
| bus_err | input | 1 | Access failed, valid with grant |
| irq | output | 1 | Channel interrupt |

## Verification
A register write lands at the next clock edge and reads back at once. The engine sees a new enable one edge later. From a request the engine needs at least one edge to reach `S_READ`, one per bus wait cycle, and one each for the two grants. The acknowledge then shows in the cycle after the write grant. Count, addresses and flags change at the edge that ends `S_ACK`. So the bench drives inputs on falling edges, waits for the acknowledge at a falling edge, drops the request there, and reads count and flags one full cycle after. The bus model uses bus latencies of 0 to 2 cycles and also checks the read-write-acknowledge order and the one-cycle gap from write grant to acknowledge.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_WAIT,
        S_READ,
        S_WRITE,
        S_ACK,
        S_DONE
    } xfer_state_t;

    // control word, bit 0 first from the right
    typedef struct packed {
        logic       teie;
        logic       htie;
        logic       tcie;
        logic [1:0] prio;
        logic       pinc;
        logic       minc;
        logic       circ;
        logic       dir;
        logic       en;
    } ctrl_t;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_COUNT = 3'd1;
    localparam logic [2:0] RA_PADDR = 3'd2;
    localparam logic [2:0] RA_MADDR = 3'd3;
    localparam logic [2:0] RA_FLAGS = 3'd4;
    localparam logic [2:0] RA_FCLR  = 3'd5;

    localparam int FLAG_TC = 0;
    localparam int FLAG_HT = 1;
    localparam int FLAG_TE = 2;
    localparam int NFLAGS  = 3;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          chan_active,
    input  logic          cnt_dec,
    input  logic          cnt_reload,
    input  logic [CW-1:0] reload_val,
    input  logic          ev_tc,
    input  logic          ev_ht,
    input  logic          ev_te,
    output ctrl_t         ctrl,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] paddr,
    output logic [AW-1:0] maddr,
    output logic          irq
);

    localparam int CTRL_W = $bits(ctrl_t);

    logic              wr_ctrl, wr_cnt, wr_paddr, wr_maddr, wr_fclr;
    logic              cnt_locked;
    logic [NFLAGS-1:0] flags, flag_clr, flag_set, flag_ie;

    assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
    assign wr_cnt   = reg_wr && (reg_addr == RA_COUNT);
    assign wr_paddr = reg_wr && (reg_addr == RA_PADDR);
    assign wr_maddr = reg_wr && (reg_addr == RA_MADDR);
    assign wr_fclr  = reg_wr && (reg_addr == RA_FCLR);

    assign cnt_locked = ctrl.en || chan_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            end
            if (ev_te) begin
                ctrl.en <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_reload) begin
            cnt <= reload_val;
        end else if (cnt_dec) begin
            cnt <= cnt - 1'b1;
        end else if (wr_cnt && !cnt_locked) begin
            cnt <= reg_wdata[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr <= '0;
            maddr <= '0;
        end else begin
            if (wr_paddr) paddr <= reg_wdata[AW-1:0];
            if (wr_maddr) maddr <= reg_wdata[AW-1:0];
        end
    end

    assign flag_clr = wr_fclr ? reg_wdata[NFLAGS-1:0] : '0;

    always_comb begin
        flag_set          = '0;
        flag_set[FLAG_TC] = ev_tc;
        flag_set[FLAG_HT] = ev_ht;
        flag_set[FLAG_TE] = ev_te;
        flag_ie           = '0;
        flag_ie[FLAG_TC]  = ctrl.tcie;
        flag_ie[FLAG_HT]  = ctrl.htie;
        flag_ie[FLAG_TE]  = ctrl.teie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~flag_clr) | flag_set;
        end
    end

    assign irq = |(flags & flag_ie);

    always_comb begin
        unique case (reg_addr)
            RA_CTRL:  reg_rdata = 32'(ctrl);
            RA_COUNT: reg_rdata = 32'(cnt);
            RA_PADDR: reg_rdata = 32'(paddr);
            RA_MADDR: reg_rdata = 32'(maddr);
            RA_FLAGS: reg_rdata = 32'(flags);
            default:  reg_rdata = '0;
        endcase
    end

    // R5: a locked count only moves by the engine's own update
    p_cnt_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && cnt_locked && !cnt_dec && !cnt_reload) |=> (cnt == $past(cnt)));

    // R7: an error leaves the channel disabled
    p_err_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_te |=> !ctrl.en);

    // R8: completion flag stays until cleared by a write of 1
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_TC] && !flag_clr[FLAG_TC]) |=> flags[FLAG_TC]);

endmodule

// File: rtl/dma_chan_xfer.sv
module dma_chan_xfer
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] paddr,
    input  logic [AW-1:0] maddr,
    input  logic          per_req,
    output logic          per_ack,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_gnt,
    input  logic          bus_err,
    output logic          chan_active,
    output logic          cnt_dec,
    output logic          cnt_reload,
    output logic [CW-1:0] reload_val,
    output logic          ev_tc,
    output logic          ev_ht,
    output logic          ev_te
);

    xfer_state_t   state, state_nx;
    logic [AW-1:0] base_p, base_m, cur_p, cur_m;
    logic [CW-1:0] shadow_cnt, cnt_after, half_mark;
    logic [DW-1:0] data_q;
    logic          ht_done;
    logic          last_item, in_bus, bus_fail;

    assign last_item = (cnt == {{(CW-1){1'b0}}, 1'b1});
    assign cnt_after = cnt - 1'b1;
    assign half_mark = shadow_cnt >> 1;
    assign in_bus    = (state == S_READ) || (state == S_WRITE);
    assign bus_fail  = in_bus && bus_gnt && bus_err;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:   if (ctrl.en) state_nx = S_WAIT;
            S_WAIT: begin
                if (!ctrl.en)          state_nx = S_OFF;
                else if (cnt == '0)    state_nx = S_DONE;
                else if (per_req)      state_nx = S_READ;
            end
            S_READ: begin
                if (bus_gnt) state_nx = bus_err ? S_OFF : S_WRITE;
            end
            S_WRITE: begin
                if (bus_gnt) state_nx = bus_err ? S_OFF : S_ACK;
            end
            S_ACK:   state_nx = (last_item && !ctrl.circ) ? S_DONE : S_WAIT;
            S_DONE:  if (!ctrl.en) state_nx = S_OFF;
            default: state_nx = S_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_p     <= '0;
            base_m     <= '0;
            cur_p      <= '0;
            cur_m      <= '0;
            shadow_cnt <= '0;
            data_q     <= '0;
            ht_done    <= 1'b0;
        end else begin
            unique case (state)
                S_OFF: begin
                    if (ctrl.en) begin
                        base_p     <= paddr;
                        base_m     <= maddr;
                        cur_p      <= paddr;
                        cur_m      <= maddr;
                        shadow_cnt <= cnt;
                        ht_done    <= 1'b0;
                    end
                end
                S_READ: begin
                    if (bus_gnt && !bus_err) data_q <= bus_rdata;
                end
                S_ACK: begin
                    if (last_item && ctrl.circ) begin
                        cur_p   <= base_p;
                        cur_m   <= base_m;
                        ht_done <= 1'b0;
                    end else begin
                        if (ctrl.pinc) cur_p <= cur_p + 1'b1;
                        if (ctrl.minc) cur_m <= cur_m + 1'b1;
                        if (ev_ht)     ht_done <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_req     = 1'b0;
        bus_we      = 1'b0;
        bus_addr    = '0;
        per_ack     = 1'b0;
        cnt_dec     = 1'b0;
        cnt_reload  = 1'b0;
        ev_tc       = 1'b0;
        ev_ht       = 1'b0;
        unique case (state)
            S_READ: begin
                bus_req  = 1'b1;
                bus_addr = ctrl.dir ? cur_m : cur_p;
            end
            S_WRITE: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = ctrl.dir ? cur_p : cur_m;
            end
            S_ACK: begin
                per_ack    = 1'b1;
                ev_tc      = last_item;
                ev_ht      = !ht_done && (cnt_after <= half_mark);
                cnt_reload = last_item && ctrl.circ;
                cnt_dec    = !(last_item && ctrl.circ);
            end
            default: ;
        endcase
    end

    assign bus_wdata   = data_q;
    assign reload_val  = shadow_cnt;
    assign ev_te       = bus_fail;
    assign chan_active = (state != S_OFF);

    // R9: request, address and direction held until grant
    p_hold_until_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R9: acknowledge lasts exactly one cycle
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);

    // R3: the count never wraps below zero
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dec |-> (cnt != '0));

    // R7: an errored access is never acknowledged
    p_err_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fail |=> !per_ack);

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          per_req,
    output logic          per_ack,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_gnt,
    input  logic          bus_err,
    output logic          irq
);

    ctrl_t         ctrl;
    logic [CW-1:0] cnt, reload_val;
    logic [AW-1:0] paddr, maddr;
    logic          chan_active, cnt_dec, cnt_reload;
    logic          ev_tc, ev_ht, ev_te;

    dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .chan_active (chan_active),
        .cnt_dec     (cnt_dec),
        .cnt_reload  (cnt_reload),
        .reload_val  (reload_val),
        .ev_tc       (ev_tc),
        .ev_ht       (ev_ht),
        .ev_te       (ev_te),
        .ctrl        (ctrl),
        .cnt         (cnt),
        .paddr       (paddr),
        .maddr       (maddr),
        .irq         (irq)
    );

    dma_chan_xfer #(.AW(AW), .CW(CW), .DW(DW)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .cnt         (cnt),
        .paddr       (paddr),
        .maddr       (maddr),
        .per_req     (per_req),
        .per_ack     (per_ack),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_gnt     (bus_gnt),
        .bus_err     (bus_err),
        .chan_active (chan_active),
        .cnt_dec     (cnt_dec),
        .cnt_reload  (cnt_reload),
        .reload_val  (reload_val),
        .ev_tc       (ev_tc),
        .ev_ht       (ev_ht),
        .ev_te       (ev_te)
    );

endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PBASE = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = '0;
    logic        bus_gnt = 1'b0;
    logic        bus_err = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // bus/peripheral model state (written only by the model block)
    logic [7:0]  src_mem [0:255];
    logic [7:0]  dst_mem [0:255];
    logic [7:0]  plog    [0:1023];
    logic [15:0] palog   [0:1023];
    int pn = 0, prd = 0, gcount = 0, wcnt = 0, cyc = 0, acks = 0;
    int viol = 0, wr_cyc = 0, reqc = 0;
    logic wr_pending = 1'b0, exp_we = 1'b0;
    // model settings (written only by the stimulus)
    int lat = 0, err_at = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_ack(per_ack), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_gnt(bus_gnt), .bus_err(bus_err), .irq(irq)
    );

    initial begin
        for (int i = 0; i < 256; i++) src_mem[i] = 8'(i * 7 + 3);
    end

    // bus responder and ordering monitor (R9)
    always @(negedge clk) begin
        cyc++;
        if (bus_req) reqc++;
        if (per_ack) begin
            acks++;
            if (!wr_pending || cyc != wr_cyc + 1) viol++;
            wr_pending = 1'b0;
        end
        if (bus_gnt) begin
            bus_gnt = 1'b0;
            bus_err = 1'b0;
            wcnt    = 0;
        end else if (bus_req) begin
            if (wcnt >= lat) begin
                bus_gnt = 1'b1;
                if (gcount == err_at) begin
                    bus_err = 1'b1;
                    exp_we  = 1'b0;
                end else begin
                    if (bus_we != exp_we) viol++;
                    if (bus_we) begin
                        if (bus_addr >= PBASE) begin
                            plog[pn]  = bus_wdata;
                            palog[pn] = bus_addr;
                            pn++;
                        end else begin
                            dst_mem[bus_addr[7:0]] = bus_wdata;
                        end
                        wr_pending = 1'b1;
                        wr_cyc     = cyc;
                    end else if (bus_addr >= PBASE) begin
                        bus_rdata = 8'(8'h40 + prd);
                        prd++;
                    end else begin
                        bus_rdata = src_mem[bus_addr[7:0]];
                    end
                    exp_we = !bus_we;
                end
                gcount++;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic one_item();
        @(negedge clk);
        per_req = 1'b1;
        do @(negedge clk); while (!per_ack);
        per_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic disarm();
        wr(3'd0, 32'd0);
        repeat (3) @(negedge clk);
        wr(3'd5, 32'h7);
    endtask

    // control word: en0 dir1 circ2 minc3 pinc4 prio6:5 tcie7 htie8 teie9
    function automatic logic [31:0] cw(input bit dir, input bit circ, input bit minc,
                                       input bit pinc, input bit tcie, input bit htie,
                                       input bit teie);
        return 32'(1 | (dir << 1) | (circ << 2) | (minc << 3) | (pinc << 4) |
                   (tcie << 7) | (htie << 8) | (teie << 9));
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        int pn0, prd0, a0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R10 register reset", v, 32'd0);
        end
        chk("R10 irq low", 32'(irq), 32'd0);
        chk("R10 bus_req low", 32'(bus_req), 32'd0);
        chk("R10 per_ack low", 32'(per_ack), 32'd0);

        // R12: priority field stored and read back, enable left clear
        wr(3'd0, 32'h0000_0060);
        rd(3'd0, v);
        chk("R12 priority readback", v, 32'h0000_0060);
        wr(3'd0, 32'd0);

        // R11: no request, no bus activity
        wr(3'd2, 32'(PBASE));
        wr(3'd3, 32'h10);
        wr(3'd1, 32'd3);
        wr(3'd0, cw(1, 0, 1, 0, 1, 0, 0));
        r0 = reqc;
        repeat (20) @(negedge clk);
        chk("R11 no bus request", 32'(reqc), 32'(r0));
        rd(3'd1, v);
        chk("R11 count held", v, 32'd3);
        disarm();

        // R1 R2 R3 R6 R8 R9: sweep count, direction, memory increment, bus latency
        for (int n = 1; n <= 5; n++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int mi = 0; mi < 2; mi++) begin
                    lat = (n + dir) % 3;
                    wr(3'd2, 32'(PBASE));
                    wr(3'd3, 32'h10);
                    wr(3'd1, 32'(n));
                    wr(3'd0, cw(dir[0], 0, mi[0], 0, 1, 0, 0));
                    pn0 = pn; prd0 = prd;
                    for (int k = 0; k < n; k++) one_item();
                    rd(3'd1, v);
                    chk("R3 count at zero", v, 32'd0);
                    rd(3'd4, v);
                    chk("R3 complete flag", 32'(v[0]), 32'd1);
                    chk("R6 half flag by end", 32'(v[1]), 32'd1);
                    chk("R8 irq from complete", 32'(irq), 32'd1);
                    a0 = acks;
                    @(negedge clk); per_req = 1'b1;
                    repeat (15) @(negedge clk);
                    per_req = 1'b0;
                    chk("R3 no service after done", 32'(acks), 32'(a0));
                    for (int k = 0; k < n; k++) begin
                        if (dir == 1) begin
                            chk("R1 mem to peripheral data", 32'(plog[pn0 + k]),
                                32'(src_mem[mi ? 16 + k : 16]));
                            chk("R2 peripheral address fixed", 32'(palog[pn0 + k]), 32'(PBASE));
                        end else if (mi == 1) begin
                            chk("R1 peripheral to mem data", 32'(dst_mem[16 + k]),
                                32'(8'(8'h40 + prd0 + k)));
                        end
                    end
                    if (dir == 0 && mi == 0)
                        chk("R2 memory address fixed", 32'(dst_mem[16]),
                            32'(8'(8'h40 + prd0 + n - 1)));
                    disarm();
                end
            end
        end
        lat = 1;

        // R2: peripheral increment
        wr(3'd2, 32'(PBASE + 4));
        wr(3'd3, 32'h30);
        wr(3'd1, 32'd3);
        wr(3'd0, cw(1, 0, 1, 1, 0, 0, 0));
        pn0 = pn;
        for (int k = 0; k < 3; k++) one_item();
        for (int k = 0; k < 3; k++)
            chk("R2 peripheral address steps", 32'(palog[pn0 + k]), 32'(PBASE + 4 + k));
        disarm();

        // R6: half flag at most once per pass, irq via half enable only
        for (int n = 4; n <= 7; n++) begin
            bit fired;
            fired = 1'b0;
            wr(3'd2, 32'(PBASE));
            wr(3'd3, 32'h40);
            wr(3'd1, 32'(n));
            wr(3'd0, cw(1, 0, 1, 0, 0, 1, 0));
            for (int k = 1; k <= n; k++) begin
                bit exp_ht;
                one_item();
                exp_ht = ((n - k) <= (n >> 1)) && !fired;
                if (exp_ht) fired = 1'b1;
                rd(3'd4, v);
                chk("R6 half flag timing", 32'(v[1]), 32'(exp_ht));
                chk("R8 irq follows half only", 32'(irq), 32'(exp_ht));
                chk("R3 complete only at end", 32'(v[0]), 32'(k == n));
                wr(3'd5, 32'h2);
            end
            disarm();
        end

        // R4: circular mode wraps count and addresses
        wr(3'd2, 32'(PBASE));
        wr(3'd3, 32'h20);
        wr(3'd1, 32'd3);
        wr(3'd0, cw(1, 1, 1, 0, 1, 0, 0));
        pn0 = pn;
        for (int k = 0; k < 8; k++) one_item();
        for (int k = 0; k < 8; k++)
            chk("R4 circular data order", 32'(plog[pn0 + k]), 32'(src_mem[32 + (k % 3)]));
        rd(3'd1, v);
        chk("R4 reloaded count", v, 32'd1);
        rd(3'd4, v);
        chk("R4 complete flag", 32'(v[0]), 32'd1);
        rd(3'd0, v);
        chk("R4 enable kept", 32'(v[0]), 32'd1);

        // R5: count write locked while enabled, accepted once off
        wr(3'd1, 32'd9);
        rd(3'd1, v);
        chk("R5 write ignored while enabled", v, 32'd1);
        disarm();
        wr(3'd1, 32'd9);
        rd(3'd1, v);
        chk("R5 write accepted when off", v, 32'd9);

        // R7: bus error on the read of the second item
        wr(3'd2, 32'(PBASE));
        wr(3'd3, 32'h50);
        wr(3'd1, 32'd4);
        wr(3'd0, cw(1, 0, 1, 0, 1, 0, 1));
        one_item();
        err_at = gcount;
        a0 = acks;
        @(negedge clk); per_req = 1'b1;
        repeat (20) @(negedge clk);
        per_req = 1'b0;
        err_at = -1;
        chk("R7 no acknowledge on error", 32'(acks), 32'(a0));
        rd(3'd4, v);
        chk("R7 error flag", 32'(v[2]), 32'd1);
        rd(3'd0, v);
        chk("R7 enable cleared", 32'(v[0]), 32'd0);
        rd(3'd1, v);
        chk("R7 count unchanged", v, 32'd3);
        chk("R8 irq from error", 32'(irq), 32'd1);

        // R8: write-one-to-clear, per bit
        wr(3'd5, 32'h1);
        rd(3'd4, v);
        chk("R8 error flag survives other clear", 32'(v[2]), 32'd1);
        wr(3'd5, 32'h4);
        rd(3'd4, v);
        chk("R8 flags cleared", v, 32'd0);
        chk("R8 irq drops", 32'(irq), 32'd0);

        // R9: ordering and acknowledge timing over the whole run
        chk("R9 read-write-ack order", 32'(viol), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule